// File: doc/BRIEF.md
# Rotating Address Register Generator

This block keeps four 32-bit address registers, g0 through g3, held together as one 128-bit state. Each cycle it forms an operand address. It XORs the low word of an integer register value with g0, then narrows the result to the width that the access needs. Scratchpad-sized accesses are also aligned to 8 bytes. The address is a combinational function of the current g0 and the inputs, so it is valid in the same cycle.

A step strobe marks that an address has been used. On that edge the four registers rotate by one position. A regenerate strobe replaces the whole 128-bit state with one AES encryption round of that state. The round key is built from the two 64-bit operand values. When both strobes are high in the same cycle, regeneration wins. The scratchpad, the ALU and the full AES cipher sit outside this block.

Top module: `agen_addr_unit`

## Requirements
- R1: While `rst_n` is low, the state resets to parameter `G_INIT`, which defaults to 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0. The state is seen on `g_state_o`.
- R2: The raw address is `reg_a_i[31:0] ^ g0`. It comes from the current g0 in the same cycle, with no register on the path.
- R3: With `width_sel_i` = 2'b00, `addr_o` is the full 32-bit raw address with no alignment.
- R4: With `width_sel_i` = 2'b01, `addr_o` keeps raw bits 17:3. Bits 31:18 and bits 2:0 are zero.
- R5: With `width_sel_i` = 2'b10 or 2'b11, `addr_o` keeps raw bits 13:3. Bits 31:14 and bits 2:0 are zero.
- R6: On a clock edge with `step_i` high and `regen_i` low, the registers rotate as g0 <= g1, g1 <= g2, g2 <= g3 and g3 <= g0.
- R7: On a clock edge with `regen_i` high, the state becomes one AES round of the state, keyed with {reg_a_i, reg_b_i}. The round applies SubBytes, ShiftRows and MixColumns, then XORs the key.
  - Byte k of the state is bits 8k+7:8k.
  - Byte k sits in row k%4 and column k/4.
  - ShiftRows sets output row r, column c to input row r, column (c+r)%4.
- R8: When `regen_i` and `step_i` are both high, only the regeneration of R7 takes place.
- R9: On an edge with neither strobe high, the state holds.
- R10: `g_state_o` is {g3, g2, g1, g0}, with g0 in bits 31:0 and g3 in bits 127:96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Address used: rotate the registers |
| regen_i | input | 1 | Replace the state with one AES round |
| reg_a_i | input | 64 | Integer register value; address source and upper key half |
| reg_b_i | input | 64 | Second operand; lower key half |
| width_sel_i | input | 2 | Address width: 00 = 32, 01 = 18, 1x = 14 |
| addr_o | output | 32 | Formed address |
| g_state_o | output | 128 | Packed address registers {g3,g2,g1,g0} |

## Verification
The hardest situation to reach is a state reached through a long mix of rotations and AES rounds whose key changes every cycle. It is hardest of all when both strobes are high together, because a rotation that wrongly leaks in is then hidden inside the round. The bench runs thousands of cycles of seeded random strobes and operands, with regeneration at roughly one edge in four. A directed stretch drives both strobes together with extreme operand patterns. Every state is compared against a bench model whose S-box is found by brute-force search for inverses, so any error in one byte is carried forward and shows up in later addresses and states.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_REGS   = 4;
  localparam int unsigned STATE_W  = WORD_W * N_REGS;
  localparam int unsigned OPND_W   = 64;

  typedef enum logic [1:0] {
    WSEL_FULL = 2'b00,
    WSEL_MID  = 2'b01,
    WSEL_NAR  = 2'b10,
    WSEL_NAR2 = 2'b11
  } wsel_e;

  // multiply by x in GF(2^8), reduction polynomial 0x11b
  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int unsigned n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/agen_aes_round.sv
module agen_aes_round
  import agen_pkg::*;
#(
  parameter int unsigned COLS = 4
) (
  input  logic [COLS*32-1:0] state_i,
  input  logic [COLS*32-1:0] key_i,
  output logic [COLS*32-1:0] state_o
);
  localparam int unsigned NB = COLS * 4;

  logic [7:0] shifted [NB];
  logic [7:0] mixed   [NB];

  genvar c, r;
  generate
    for (c = 0; c < COLS; c++) begin : g_col
      for (r = 0; r < 4; r++) begin : g_row
        localparam int unsigned SRC = r + 4 * ((c + r) % COLS);
        assign shifted[r + 4*c] = sub_byte(state_i[8*SRC +: 8]);
      end
      always_comb begin
        mixed[4*c+0] = gf_xtime(shifted[4*c+0]) ^ gf_xtime(shifted[4*c+1]) ^ shifted[4*c+1]
                       ^ shifted[4*c+2] ^ shifted[4*c+3];
        mixed[4*c+1] = shifted[4*c+0] ^ gf_xtime(shifted[4*c+1]) ^ gf_xtime(shifted[4*c+2])
                       ^ shifted[4*c+2] ^ shifted[4*c+3];
        mixed[4*c+2] = shifted[4*c+0] ^ shifted[4*c+1] ^ gf_xtime(shifted[4*c+2])
                       ^ gf_xtime(shifted[4*c+3]) ^ shifted[4*c+3];
        mixed[4*c+3] = gf_xtime(shifted[4*c+0]) ^ shifted[4*c+0] ^ shifted[4*c+1]
                       ^ shifted[4*c+2] ^ gf_xtime(shifted[4*c+3]);
      end
      for (r = 0; r < 4; r++) begin : g_out
        assign state_o[8*(r+4*c) +: 8] = mixed[r + 4*c] ^ key_i[8*(r+4*c) +: 8];
      end
    end
  endgenerate
endmodule

// File: rtl/agen_addr_fmt.sv
module agen_addr_fmt
  import agen_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned MID_W    = 18,
  parameter int unsigned NAR_W    = 14,
  parameter int unsigned ALIGN_LG = 3
) (
  input  logic [AW-1:0] raw_i,
  input  logic [1:0]    wsel_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] MID_MASK = ((AW'(1) << MID_W) - AW'(1)) & ~((AW'(1) << ALIGN_LG) - AW'(1));
  localparam logic [AW-1:0] NAR_MASK = ((AW'(1) << NAR_W) - AW'(1)) & ~((AW'(1) << ALIGN_LG) - AW'(1));

  always_comb begin
    unique case (wsel_e'(wsel_i))
      WSEL_FULL: addr_o = raw_i;
      WSEL_MID:  addr_o = raw_i & MID_MASK;
      default:   addr_o = raw_i & NAR_MASK;
    endcase
  end
endmodule

// File: rtl/agen_addr_unit.sv
module agen_addr_unit
  import agen_pkg::*;
#(
  parameter logic [127:0] G_INIT = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         regen_i,
  input  logic [63:0]  reg_a_i,
  input  logic [63:0]  reg_b_i,
  input  logic [1:0]   width_sel_i,
  output logic [31:0]  addr_o,
  output logic [127:0] g_state_o
);
  logic [WORD_W-1:0]  g_q [N_REGS];
  logic [WORD_W-1:0]  g_rot [N_REGS];
  logic [STATE_W-1:0] packed_q;
  logic [STATE_W-1:0] aes_next;
  logic [WORD_W-1:0]  raw_addr;
  logic               do_regen;
  logic               do_rotate;

  assign do_regen  = regen_i;
  assign do_rotate = step_i & ~regen_i;

  genvar i;
  generate
    for (i = 0; i < N_REGS; i++) begin : g_pack
      assign packed_q[WORD_W*i +: WORD_W] = g_q[i];
      assign g_rot[i] = g_q[(i + 1) % N_REGS];
    end
  endgenerate

  agen_aes_round #(.COLS(N_REGS)) u_round (
    .state_i (packed_q),
    .key_i   ({reg_a_i, reg_b_i}),
    .state_o (aes_next)
  );

  assign raw_addr = reg_a_i[WORD_W-1:0] ^ g_q[0];

  agen_addr_fmt #(.AW(WORD_W)) u_fmt (
    .raw_i  (raw_addr),
    .wsel_i (width_sel_i),
    .addr_o (addr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_REGS; k++) g_q[k] <= G_INIT[WORD_W*k +: WORD_W];
    end else if (do_regen) begin
      for (int k = 0; k < N_REGS; k++) g_q[k] <= aes_next[WORD_W*k +: WORD_W];
    end else if (do_rotate) begin
      for (int k = 0; k < N_REGS; k++) g_q[k] <= g_rot[k];
    end
  end

  assign g_state_o = packed_q;

  // R6: rotation moves every word down by one place
  assert_rotate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !regen_i) |=> (g_state_o == {$past(g_state_o[31:0]), $past(g_state_o[127:32])}));

  // R7 / R8: regeneration loads the round result, step ignored
  assert_regen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    regen_i |=> (g_state_o == $past(aes_next)));

  // R9: idle edge keeps state
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !regen_i) |=> $stable(g_state_o));

  // R4: mid width is aligned and bounded
  assert_mid_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel_i == 2'b01) |-> (addr_o[31:18] == '0 && addr_o[2:0] == '0));

  // R5: narrow width is aligned and bounded
  assert_nar_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel_i[1]) |-> (addr_o[31:14] == '0 && addr_o[2:0] == '0));
endmodule

// File: tb/agen_addr_unit_test.sv
`timescale 1ns/1ps
module agen_addr_unit_test;
  localparam logic [127:0] INIT = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         step_i, regen_i;
  logic [63:0]  reg_a_i, reg_b_i;
  logic [1:0]   width_sel_i;
  logic [31:0]  addr_o;
  logic [127:0] g_state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0]   sbox_t [256];
  logic [127:0] model;

  always #4 clk = ~clk;

  agen_addr_unit uut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .regen_i(regen_i),
    .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .width_sel_i(width_sel_i),
    .addr_o(addr_o), .g_state_o(g_state_o)
  );

  function automatic logic [7:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod = 0;
    for (int i = 0; i < 8; i++) if (b[i]) prod ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (prod[i]) prod ^= 16'h11b << (i - 8);
    return prod[7:0];
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b);
    logic [7:0] s;
    for (int i = 0; i < 8; i++)
      s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ (8'h63 >> i);
    return s;
  endfunction

  function automatic logic [127:0] ref_round(input logic [127:0] st, input logic [127:0] key);
    logic [7:0] t [16];
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        t[r + 4*c] = sbox_t[st[8*(r + 4*((c + r) % 4)) +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 0;
        for (int k = 0; k < 4; k++) begin
          int d = (k - r + 4) % 4;
          acc ^= mul8(t[k + 4*c], d == 0 ? 8'd2 : (d == 1 ? 8'd3 : 8'd1));
        end
        o[8*(r + 4*c) +: 8] = acc ^ key[8*(r + 4*c) +: 8];
      end
    return o;
  endfunction

  function automatic logic [31:0] ref_addr(input logic [31:0] g0, input logic [63:0] a, input logic [1:0] w);
    logic [31:0] raw = a[31:0] ^ g0;
    if (w == 2'b00) return raw;
    if (w == 2'b01) return {14'd0, raw[17:3], 3'd0};
    return {18'd0, raw[13:3], 3'd0};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // one cycle: drive at negedge, check address, then the state after the edge
  task automatic cyc(input logic st, input logic rg, input logic [63:0] a, input logic [63:0] b,
                     input logic [1:0] w);
    @(negedge clk);
    step_i = st; regen_i = rg; reg_a_i = a; reg_b_i = b; width_sel_i = w;
    #1;
    check(w == 2'b00 ? "R2/R3 addr" : (w == 2'b01 ? "R4 addr" : "R5 addr"),
          128'(addr_o), 128'(ref_addr(model[31:0], a, w)));
    if (rg) model = ref_round(model, {a, b});
    else if (st) model = {model[31:0], model[127:32]};
    @(posedge clk); #1;
    check(rg ? (st ? "R8 regen+step" : "R7 regen") : (st ? "R6 rotate" : "R9 hold"),
          g_state_o, model);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int v = 0; v < 256; v++) begin
      logic [7:0] inv = 0;
      for (int u = 1; u < 256; u++) if (mul8(8'(v), 8'(u)) == 8'h01) inv = 8'(u);
      sbox_t[v] = affine(inv);
    end
    rst_n = 0; step_i = 0; regen_i = 0; reg_a_i = 0; reg_b_i = 0; width_sel_i = 0;
    repeat (3) @(posedge clk);
    #1;
    model = INIT;
    check("R1 reset state", g_state_o, INIT);
    check("R10 g0 position", 128'(g_state_o[31:0]), 128'(32'hc3d2e1f0));
    @(negedge clk); rst_n = 1;

    // directed corners
    cyc(0, 0, 64'h0, 64'h0, 2'b00);
    cyc(0, 0, 64'hffff_ffff_ffff_ffff, 64'h0, 2'b01);
    cyc(1, 0, 64'hffff_ffff_ffff_ffff, 64'h0, 2'b10);
    cyc(1, 0, 64'h0, 64'h0, 2'b11);
    cyc(1, 0, 64'h1234_5678_9abc_def0, 64'h0, 2'b00);
    cyc(1, 0, 64'h0, 64'h0, 2'b00);
    check("R6 four rotations return", g_state_o, {INIT[63:0], INIT[127:64]} == 128'h0 ? 128'h0 : model);
    cyc(0, 1, 64'h0, 64'h0, 2'b00);
    cyc(1, 1, 64'hffff_ffff_ffff_ffff, 64'haaaa_5555_aaaa_5555, 2'b01);
    cyc(1, 1, 64'h8000_0000_0000_0001, 64'hffff_ffff_ffff_ffff, 2'b11);
    cyc(0, 0, 64'h0, 64'h0, 2'b00);

    // seeded random mix
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      cyc(($urandom % 2) == 1, ($urandom % 4) == 0, a, b, 2'($urandom));
    end
    report();
  end
endmodule